// File: doc/BRIEF.md
# Banked Half-Bridge Control and Fault Register

This block holds the control state behind a serial command port for eight half-bridge output stages and tracks their fault state. Each committed 16-bit command word carries a group flag. Group 0 covers bridges 1 to 6 and group 1 covers bridges 7 and 8. A write updates the enable and drive-side bits of the addressed group only. The same flag sets the scope of a status-clear request and chooses which open-load shutdown enable bit is written.

Raw, already-qualified fault events come in per channel: over-current pulses, open-load pulses and per-channel over-temperature levels. Supply faults and the thermal warning come in as live levels. Over-current, open-load and over-temperature faults are held in latches. Supply-fail and thermal warning are reported live. Both kinds are combined into one status word for the group named by the last command.

The block drives a pair of gate enables for each bridge, one high-side and one low-side. These are the final product of the configuration, the latched faults and the live supply conditions.

Top module: `hbridge_bank_regs`

## Requirements
- R1: While `rst_ni` is low and right after it rises, every control bit is 0, every latched fault is clear, `status_o` is 0, `tsd_flag_o` is 0 and all gate enables are low.
- R2: While `enable_i` is low, all gate enables are low and commands are ignored. Every clock edge with `enable_i` low clears all control bits and all latched faults. After `enable_i` rises again, the bridges stay off until they are written.
- R3: A group-0 command has bit 14 = 0. Bits 12..7 enable bridges 6..1 and bits 6..1 choose the drive side of bridges 6..1. With group 0 selected, the status word returns the effective active state of bridges 6..1 in bits 12..7 and their drive side in bits 6..1.
- R4: A group-1 command has bit 14 = 1. Bits 8..7 enable bridges 8..7 and bits 2..1 choose their drive side. All other bits of a group-1 command are ignored. With group 1 selected, status bits 12..9 and 6..3 read 0. A group-1 write leaves group 0 unchanged.
- R5: A bridge that is not active drives both of its gate enables low. An active bridge drives only the high side when its drive-side bit is 1, and only the low side when it is 0.
- R6: An over-current event on a channel latches status bit 15 for that channel's group and turns the channel off from the next cycle.
- R7: An open-load event always latches status bit 13 for its group. The channel is turned off only while that group's open-load shutdown bit (command bit 13) is 1.
- R8: An over-temperature level latches `tsd_flag_o` and turns the channel off. The latch is released only by a status clear for its group that arrives after the level has dropped.
- R9: A command with bit 15 = 1 clears the latched faults of its own group only, which re-activates that group's faulted outputs. The other group's latches are kept.
- R10: A fault event in the same cycle as a status clear for its group leaves the fault latched.
- R11: Status bit 14 reads `ov_i | uv_i` live. `uv_i` turns all outputs off. `ov_i` turns all outputs off only while the lockout bit (command bit 0 of the last write) is 1. Outputs come back when the supply condition goes away.
- R12: Status bit 0 reads `warm_i` live and has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low logic power-on reset |
| enable_i | input | 1 | Low puts the block to sleep and clears it |
| cmd_i | input | 16 | Committed command word |
| cmd_valid_i | input | 1 | One-cycle strobe that commits `cmd_i` |
| oc_evt_i | input | 8 | Per-channel over-current event |
| ol_evt_i | input | 8 | Per-channel open-load event |
| hot_i | input | 8 | Per-channel over-temperature level |
| ov_i | input | 1 | Supply over-voltage level |
| uv_i | input | 1 | Supply under-voltage level |
| warm_i | input | 1 | Thermal warning level |
| status_o | output | 16 | Status word of the selected group |
| tsd_flag_o | output | 1 | Any channel holds a latched over-temperature |
| hs_on_o | output | 8 | High-side gate enable per bridge |
| ls_on_o | output | 8 | Low-side gate enable per bridge |

## Verification
The bench sweeps every enable and drive-side pattern of group 0, and every pattern of group 1 with all ignored bits set. A wrong field decode shows up as a wrong gate pair, and a leak of ignored bits shows up as nonzero reserved status bits.

For each channel it injects an over-current, then sends a status clear to the other group and to its own group. A design with the wrong clear scope either revives the wrong channel or keeps a channel dead. A design that lets the clear beat a fault arriving in the same cycle loses the flag.

It also checks three timing-sensitive cases:
- An over-temperature latch must survive a clear sent while the channel is still hot.
- An open-load fault must only cut the output once shutdown is enabled.
- A sleep period must erase everything, including writes made during it.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
    localparam int CMD_W = 16;
    localparam int LO_CH = 6;
    localparam int HI_CH = 2;
    localparam int NCH   = LO_CH + HI_CH;

    // command field positions
    localparam int B_CLR  = 15;
    localparam int B_GRP  = 14;
    localparam int B_OLSD = 13;
    localparam int B_ENA  = 7;
    localparam int B_CFG  = 1;
    localparam int B_OVLO = 0;

    // status field positions
    localparam int S_OC  = 15;
    localparam int S_PSF = 14;
    localparam int S_OL  = 13;
    localparam int S_TW  = 0;

    typedef struct packed {
        logic [NCH-1:0] ena;
        logic [NCH-1:0] cfg;
        logic [1:0]     olsd;
        logic           ovlo;
        logic           grp;
    } ctrl_t;

    function automatic logic [NCH-1:0] group_mask(input logic g);
        return g ? {{HI_CH{1'b1}}, {LO_CH{1'b0}}} : {{HI_CH{1'b0}}, {LO_CH{1'b1}}};
    endfunction
endpackage

// File: rtl/hbb_cmd_decode.sv
module hbb_cmd_decode
    import hbb_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  ctrl_t            cur_i,
    output ctrl_t            nxt_o,
    output logic             clr_req_o
);
    always_comb begin
        nxt_o      = cur_i;
        nxt_o.grp  = cmd_i[B_GRP];
        nxt_o.ovlo = cmd_i[B_OVLO];
        nxt_o.olsd[cmd_i[B_GRP]] = cmd_i[B_OLSD];
        if (cmd_i[B_GRP]) begin
            nxt_o.ena[NCH-1:LO_CH] = cmd_i[B_ENA +: HI_CH];
            nxt_o.cfg[NCH-1:LO_CH] = cmd_i[B_CFG +: HI_CH];
        end else begin
            nxt_o.ena[LO_CH-1:0] = cmd_i[B_ENA +: LO_CH];
            nxt_o.cfg[LO_CH-1:0] = cmd_i[B_CFG +: LO_CH];
        end
    end

    assign clr_req_o = cmd_i[B_CLR];
endmodule

// File: rtl/hbb_fault_latch.sv
module hbb_fault_latch #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wipe_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag_d, flag_q;

    // set beats clear; sleep beats everything
    always_comb begin
        if (wipe_i) flag_d = '0;
        else        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/hbb_status_pack.sv
module hbb_status_pack
    import hbb_pkg::*;
(
    input  logic             grp_i,
    input  logic [NCH-1:0]   act_i,
    input  logic [NCH-1:0]   cfg_i,
    input  logic [NCH-1:0]   oc_i,
    input  logic [NCH-1:0]   ol_i,
    input  logic             psf_i,
    input  logic             tw_i,
    output logic [CMD_W-1:0] status_o
);
    logic [NCH-1:0] sel;

    always_comb begin
        sel             = group_mask(grp_i);
        status_o        = '0;
        status_o[S_OC]  = |(oc_i & sel);
        status_o[S_PSF] = psf_i;
        status_o[S_OL]  = |(ol_i & sel);
        status_o[S_TW]  = tw_i;
        if (grp_i) begin
            status_o[B_ENA +: HI_CH] = act_i[NCH-1:LO_CH];
            status_o[B_CFG +: HI_CH] = cfg_i[NCH-1:LO_CH];
        end else begin
            status_o[B_ENA +: LO_CH] = act_i[LO_CH-1:0];
            status_o[B_CFG +: LO_CH] = cfg_i[LO_CH-1:0];
        end
    end
endmodule

// File: rtl/hbridge_bank_regs.sv
module hbridge_bank_regs
    import hbb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             cmd_valid_i,
    input  logic [NCH-1:0]   oc_evt_i,
    input  logic [NCH-1:0]   ol_evt_i,
    input  logic [NCH-1:0]   hot_i,
    input  logic             ov_i,
    input  logic             uv_i,
    input  logic             warm_i,
    output logic [CMD_W-1:0] status_o,
    output logic             tsd_flag_o,
    output logic [NCH-1:0]   hs_on_o,
    output logic [NCH-1:0]   ls_on_o
);
    ctrl_t          ctrl_d, ctrl_q, ctrl_cmd;
    logic           clr_req;
    logic [NCH-1:0] clr_mask;
    logic [NCH-1:0] oc_q, ol_q, tsd_q;
    logic [NCH-1:0] act;
    logic           supply_off;
    logic           sel_grp;

    hbb_cmd_decode u_dec (
        .cmd_i     (cmd_i),
        .cur_i     (ctrl_q),
        .nxt_o     (ctrl_cmd),
        .clr_req_o (clr_req)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (!enable_i)        ctrl_d = '0;
        else if (cmd_valid_i) ctrl_d = ctrl_cmd;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign clr_mask = (enable_i && cmd_valid_i && clr_req) ? group_mask(cmd_i[B_GRP]) : '0;

    hbb_fault_latch #(.W(NCH)) u_oc (
        .clk_i (clk_i), .rst_ni (rst_ni), .wipe_i (!enable_i),
        .set_i (oc_evt_i), .clr_i (clr_mask), .q_o (oc_q)
    );

    hbb_fault_latch #(.W(NCH)) u_ol (
        .clk_i (clk_i), .rst_ni (rst_ni), .wipe_i (!enable_i),
        .set_i (ol_evt_i), .clr_i (clr_mask), .q_o (ol_q)
    );

    // a still-hot channel re-sets its latch, so a clear only sticks once cool
    hbb_fault_latch #(.W(NCH)) u_tsd (
        .clk_i (clk_i), .rst_ni (rst_ni), .wipe_i (!enable_i),
        .set_i (hot_i), .clr_i (clr_mask), .q_o (tsd_q)
    );

    assign supply_off = uv_i | (ov_i & ctrl_q.ovlo);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int GRP = (i < LO_CH) ? 0 : 1;
        assign act[i] = enable_i & ctrl_q.ena[i] & ~oc_q[i] & ~tsd_q[i]
                      & ~(ol_q[i] & ctrl_q.olsd[GRP]) & ~supply_off;
    end

    assign hs_on_o    = act & ctrl_q.cfg;
    assign ls_on_o    = act & ~ctrl_q.cfg;
    assign tsd_flag_o = |tsd_q;
    assign sel_grp    = ctrl_q.grp;

    hbb_status_pack u_pack (
        .grp_i    (ctrl_q.grp),
        .act_i    (act),
        .cfg_i    (ctrl_q.cfg),
        .oc_i     (oc_q),
        .ol_i     (ol_q),
        .psf_i    (ov_i | uv_i),
        .tw_i     (warm_i),
        .status_o (status_o)
    );
endmodule

// File: rtl/hbb_checker.sv
module hbb_checker
    import hbb_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic [NCH-1:0]   oc_evt_i,
    input logic [NCH-1:0]   hot_i,
    input logic [CMD_W-1:0] status_o,
    input logic             tsd_flag_o,
    input logic [NCH-1:0]   hs_on_o,
    input logic [NCH-1:0]   ls_on_o,
    input logic             sel_grp
);
    assert_oc_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && (|oc_evt_i)) |=> (((hs_on_o | ls_on_o) & $past(oc_evt_i)) == '0));

    assert_sleep_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!status_o[S_OC] && !status_o[S_OL] && !tsd_flag_o));

    assert_tsd_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && (|hot_i)) |=> tsd_flag_o);

    assert_reserved_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_grp |-> (status_o[12:9] == 4'b0 && status_o[6:3] == 4'b0));
endmodule

bind hbridge_bank_regs hbb_checker u_chk (.*);

// File: tb/hbridge_bank_regs_test.sv
module hbridge_bank_regs_test;
    import hbb_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, en, cmd_valid, ov, uv, warm;
    logic [15:0] cmd;
    logic [7:0]  oc_evt, ol_evt, hot;
    logic [15:0] status;
    logic        tsd_flag;
    logic [7:0]  hs_on, ls_on;

    hbridge_bank_regs uut (
        .clk_i (clk), .rst_ni (rst_n), .enable_i (en),
        .cmd_i (cmd), .cmd_valid_i (cmd_valid),
        .oc_evt_i (oc_evt), .ol_evt_i (ol_evt), .hot_i (hot),
        .ov_i (ov), .uv_i (uv), .warm_i (warm),
        .status_o (status), .tsd_flag_o (tsd_flag),
        .hs_on_o (hs_on), .ls_on_o (ls_on)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model of the requirements
    logic [7:0] m_ena = '0, m_cfg = '0, m_oc = '0, m_ol = '0, m_tsd = '0;
    logic [1:0] m_olsd = '0;
    logic       m_ovlo = 1'b0, m_grp = 1'b0;

    function automatic logic [7:0] e_act();
        logic [7:0] a;
        for (int i = 0; i < 8; i++) begin
            a[i] = en && m_ena[i] && !m_oc[i] && !m_tsd[i]
                && !(m_ol[i] && m_olsd[(i >= 6) ? 1 : 0]) && !uv && !(ov && m_ovlo);
        end
        return a;
    endfunction

    function automatic logic [15:0] e_stat();
        logic [7:0] a;
        a = e_act();
        if (m_grp)
            return {|m_oc[7:6], ov | uv, |m_ol[7:6], 4'b0, a[7:6], 4'b0, m_cfg[7:6], warm};
        else
            return {|m_oc[5:0], ov | uv, |m_ol[5:0], a[5:0], m_cfg[5:0], warm};
    endfunction

    function automatic logic [15:0] mk(input logic g, input logic clr);
        if (g) return {clr, 1'b1, m_olsd[1], 4'b0, m_ena[7:6], 4'b0, m_cfg[7:6], m_ovlo};
        else   return {clr, 1'b0, m_olsd[0], m_ena[5:0], m_cfg[5:0], m_ovlo};
    endfunction

    task automatic chk(input string tag);
        logic [7:0]  a;
        logic [15:0] es;
        logic        et;
        a  = e_act();
        es = e_stat();
        et = |m_tsd;
        checks++;
        if (status !== es || tsd_flag !== et || hs_on !== (a & m_cfg) || ls_on !== (a & ~m_cfg)) begin
            fails++;
            $display("FAIL %s: got status=%h tsd=%b hs=%b ls=%b expected status=%h tsd=%b hs=%b ls=%b",
                     tag, status, tsd_flag, hs_on, ls_on, es, et, a & m_cfg, a & ~m_cfg);
        end
    endtask

    // called at a falling edge; applies inputs over one rising edge
    task automatic step(input logic [15:0] c, input logic v, input logic [7:0] oc, input logic [7:0] ol);
        logic [7:0] mask;
        cmd = c; cmd_valid = v; oc_evt = oc; ol_evt = ol;
        if (!en) begin
            m_ena = '0; m_cfg = '0; m_oc = '0; m_ol = '0; m_tsd = '0;
            m_olsd = '0; m_ovlo = 1'b0; m_grp = 1'b0;
        end else begin
            mask = '0;
            if (v && c[15]) mask = c[14] ? 8'hC0 : 8'h3F;
            m_oc  = (m_oc & ~mask) | oc;
            m_ol  = (m_ol & ~mask) | ol;
            m_tsd = (m_tsd & ~mask) | hot;
            if (v) begin
                m_grp = c[14];
                m_ovlo = c[0];
                m_olsd[c[14]] = c[13];
                if (c[14]) begin
                    m_ena[7:6] = c[8:7];
                    m_cfg[7:6] = c[2:1];
                end else begin
                    m_ena[5:0] = c[12:7];
                    m_cfg[5:0] = c[6:1];
                end
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0; oc_evt = '0; ol_evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: got no finish expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; cmd_valid = 1'b0; cmd = '0;
        oc_evt = '0; ol_evt = '0; hot = '0; ov = 1'b0; uv = 1'b0; warm = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset");

        // R3 / R5: every group-0 enable pattern with varied drive sides
        for (int p = 0; p < 64; p++) begin
            step({3'b000, p[5:0], p[5:0] ^ 6'h2D, 1'b0}, 1'b1, '0, '0);
            chk("R3 R5 group0 sweep");
        end

        // R4: every group-1 pattern with ignored bits set
        for (int q = 0; q < 16; q++) begin
            step({3'b010, 4'hF, q[3:2], 4'hF, q[1:0], 1'b0}, 1'b1, '0, '0);
            chk("R4 group1 sweep");
        end

        // all bridges on, mixed sides
        step({3'b000, 6'h3F, 6'b101010, 1'b0}, 1'b1, '0, '0);
        step({3'b010, 4'h0, 2'b11, 4'h0, 2'b01, 1'b0}, 1'b1, '0, '0);
        chk("R5 all on");

        // R6 / R9 per channel
        for (int i = 0; i < 8; i++) begin
            logic g;
            g = (i >= 6);
            step(16'h0, 1'b0, 8'(1 << i), '0);
            chk("R6 over-current latch");
            step(mk(!g, 1'b1), 1'b1, '0, '0);
            chk("R9 other group clear keeps fault");
            step(mk(g, 1'b1), 1'b1, '0, '0);
            chk("R9 own group clear");
        end

        // R10: fault and clear in the same cycle
        step(mk(1'b0, 1'b1), 1'b1, 8'h01, '0);
        chk("R10 fault beats clear");
        step(mk(1'b0, 1'b1), 1'b1, '0, '0);
        chk("R10 later clear");

        // R7: open load without and with shutdown
        step(16'h0, 1'b0, '0, 8'h04);
        chk("R7 latched, output kept");
        step(mk(1'b0, 1'b0) | 16'h2000, 1'b1, '0, '0);
        chk("R7 shutdown enabled");
        step(mk(1'b0, 1'b1), 1'b1, '0, '0);
        chk("R7 R9 cleared");
        step(mk(1'b1, 1'b0) | 16'h2000, 1'b1, '0, 8'h80);
        chk("R7 group1 shutdown");
        step(mk(1'b1, 1'b1), 1'b1, '0, '0);
        chk("R7 group1 cleared");
        step(mk(1'b0, 1'b0) & ~16'h2000, 1'b1, '0, '0);

        // R8: over-temperature
        hot = 8'h40;
        step(16'h0, 1'b0, '0, '0);
        chk("R8 latched");
        step(mk(1'b1, 1'b1), 1'b1, '0, '0);
        chk("R8 clear while hot ignored");
        hot = 8'h00;
        step(16'h0, 1'b0, '0, '0);
        chk("R8 cool but still latched");
        step(mk(1'b1, 1'b1), 1'b1, '0, '0);
        chk("R8 released");
        hot = 8'h02;
        step(16'h0, 1'b0, '0, '0);
        hot = 8'h00;
        step(mk(1'b1, 1'b1), 1'b1, '0, '0);
        chk("R9 group1 clear leaves group0 thermal");
        step(mk(1'b0, 1'b1), 1'b1, '0, '0);
        chk("R9 group0 thermal cleared");

        // R11: supply
        uv = 1'b1; step(16'h0, 1'b0, '0, '0); chk("R11 undervoltage off");
        uv = 1'b0; step(16'h0, 1'b0, '0, '0); chk("R11 undervoltage recover");
        ov = 1'b1; step(16'h0, 1'b0, '0, '0); chk("R11 overvoltage, lockout off");
        step(mk(1'b0, 1'b0) | 16'h0001, 1'b1, '0, '0); chk("R11 overvoltage lockout on");
        ov = 1'b0; step(16'h0, 1'b0, '0, '0); chk("R11 overvoltage recover");
        step(mk(1'b0, 1'b0) & ~16'h0001, 1'b1, '0, '0);

        // R12: warning
        warm = 1'b1; step(16'h0, 1'b0, '0, '0); chk("R12 warning");
        warm = 1'b0; step(16'h0, 1'b0, '0, '0); chk("R12 warning gone");

        // R2: sleep
        step(16'h0, 1'b0, 8'hFF, 8'hFF);
        chk("R2 faults before sleep");
        en = 1'b0; step(16'h0, 1'b0, '0, '0); chk("R2 sleeping");
        step({3'b000, 6'h3F, 6'h3F, 1'b0}, 1'b1, 8'h10, '0); chk("R2 write in sleep ignored");
        en = 1'b1; step(16'h0, 1'b0, '0, '0); chk("R2 wake cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule